// File: doc/BRIEF.md
# Approximate Output-Stationary Systolic Matrix Engine

This block multiplies an S x S activation tile by an S x S weight tile over a programmable inner length K on a square grid of processing elements. Each element keeps its own running sum for the whole tile. One step of the inner dimension is presented per accepted cycle: a column of activations (one per row) and a row of weights (one per column). Shared per-row and per-column truncation stages clear a parameterized number of low-order operand bits. Internal skew registers then delay row r by r cycles and column c by c cycles, and the operands travel one neighbour per cycle: rightward for activations, downward for weights.

Each element multiplies its truncated operands exactly and folds the product into its local sum with a lower-part-OR adder. In that adder the low M bits are approximated and the upper bits are added exactly. A start pulse clears every sum. After the final element has taken its last product, the block raises a one-cycle completion pulse and then presents the result grid one row per cycle. Operands and results are unsigned. With zero truncation and M = 0 the block computes an exact integer matrix product.

The grid side must be at least 2.

Top module: `osa_array`

## Requirements
- R1: While reset is held and right after it is released, `done_o` and `res_valid_o` are low.
- R2: Before each multiply, the low `A_TRUNC` bits of every activation and the low `W_TRUNC` bits of every weight are replaced with zeros. With the default `A_TRUNC = 1`, an activation of value 1 contributes nothing.
- R3: Each accumulation step forms result bits below M as the bitwise OR of the two addends' low M bits. The bits from M upward are the exact sum of the upper parts plus a carry-in equal to the AND of both addends' bit M-1. Example with M = 4: adding 8 three times from zero gives 8, then 24, then 40.
- R4: After a tile, element (r,c) holds the accumulation (R2, R3) of products of activation `act_i[r*DW +: DW]` and weight `wgt_i[c*WW +: WW]` over the K accepted steps, in the order they were accepted.
- R5: `done_o` is high for exactly one cycle. It rises 2S-1 clock edges after the edge that accepts the K-th step.
- R6: Beginning on the cycle after `done_o`, rows 0 to S-1 appear on S consecutive cycles with `res_valid_o` high. `res_row_o` carries the row index, and column c of that row is on `res_data_o[c*AW +: AW]`.
- R7: A step is accepted only on a cycle with `feed_i` high while a tile is in progress. Cycles with `feed_i` low inside a tile do not count and do not change any sum.
- R8: Accepting a start clears all sums, so a result contains nothing from an earlier tile.
- R9: `start_i` is ignored while a tile is in progress or being read out, and `feed_i` is ignored while idle.
- R10: A start with `k_len_i` equal to 0 is ignored. No completion pulse or readout follows.
- R11: With `A_TRUNC = 0`, `W_TRUNC = 0` and `LOA_M = 0`, every result equals the exact integer dot product.
- R12: The sum width AW = DW + WW + log2(K_MAX) holds K_MAX products of all-ones operands without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tile (accepted when idle) |
| k_len_i | input | $clog2(K_MAX+1) | Inner length K of the tile, sampled with start |
| feed_i | input | 1 | Operand step present this cycle |
| act_i | input | S*DW | Activation per row, row r at bits r*DW |
| wgt_i | input | S*WW | Weight per column, column c at bits c*WW |
| done_o | output | 1 | One-cycle completion pulse |
| res_valid_o | output | 1 | A result row is presented |
| res_row_o | output | $clog2(S) | Index of the presented row |
| res_data_o | output | S*AW | Row sums, column c at bits c*AW |

## Verification
Result timing is measured from the clock edge that accepts the last step of a tile. The completion pulse is due 2S-1 edges later, and row r is due 2S+r edges later. After driving the final step, the bench samples on every falling edge over a window of 3S+2 cycles. In each sampled cycle it compares `done_o` and `res_valid_o` against those exact indices and checks row data only in its own due cycle, so an early or late output, or an extra one, shows up as a mismatch. The R10 check watches the same window after a zero-length start and expects both outputs to stay low throughout.

// File: rtl/osa_pkg.sv
package osa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FEED,
    ST_DRAIN,
    ST_DONE,
    ST_READ
  } osa_state_e;
endpackage

// File: rtl/osa_trunc.sv
// Shared pre-approximation stage: clears the low T bits.
module osa_trunc #(
  parameter int W = 8,
  parameter int T = 0
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] KEEP = ~((W'(1) << T) - W'(1));
  assign q_o = d_i & KEEP;
endmodule

// File: rtl/osa_loa_add.sv
// Lower-part-OR adder, 0 <= M < W.
module osa_loa_add #(
  parameter int W = 20,
  parameter int M = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  if (M == 0) begin : g_exact
    assign sum_o = a_i + b_i;
  end else begin : g_loa
    logic         cin;
    logic [W-M-1:0] hi;
    assign cin   = a_i[M-1] & b_i[M-1];
    assign hi    = a_i[W-1:M] + b_i[W-1:M] + (W-M)'(cin);
    assign sum_o = {hi, a_i[M-1:0] | b_i[M-1:0]};
  end
endmodule

// File: rtl/osa_pe.sv
module osa_pe #(
  parameter int DW = 8,
  parameter int WW = 8,
  parameter int AW = 20,
  parameter int M  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          v_i,
  input  logic [DW-1:0] a_i,
  input  logic [WW-1:0] w_i,
  output logic [AW-1:0] acc_o
);
  localparam int PW = DW + WW;

  logic [PW-1:0] prod;
  logic [AW-1:0] sum;
  logic [AW-1:0] acc_q;

  assign prod = PW'(a_i) * PW'(w_i);

  osa_loa_add #(.W(AW), .M(M)) u_add (
    .a_i  (acc_q),
    .b_i  (AW'(prod)),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (v_i)     acc_q <= sum;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/osa_ctrl.sv
module osa_ctrl
  import osa_pkg::*;
#(
  parameter int S     = 4,
  parameter int K_MAX = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [$clog2(K_MAX+1)-1:0] k_len_i,
  input  logic                       feed_i,
  output logic                       clear_o,
  output logic                       step_o,
  output logic                       done_o,
  output logic                       res_valid_o,
  output logic [((S>1)?$clog2(S):1)-1:0] row_o
);
  localparam int KW  = $clog2(K_MAX+1);
  localparam int RW  = (S > 1) ? $clog2(S) : 1;
  localparam int DCW = $clog2(2*S);

  osa_state_e    state_q;
  logic [KW-1:0] k_q;
  logic [KW-1:0] feed_cnt_q;
  logic [DCW-1:0] drain_q;
  logic [RW-1:0] row_q;

  assign clear_o     = (state_q == ST_IDLE) && start_i && (k_len_i != '0);
  assign step_o      = (state_q == ST_FEED) && feed_i;
  assign done_o      = (state_q == ST_DONE);
  assign res_valid_o = (state_q == ST_READ);
  assign row_o       = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      k_q        <= '0;
      feed_cnt_q <= '0;
      drain_q    <= '0;
      row_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && (k_len_i != '0)) begin
            state_q    <= ST_FEED;
            k_q        <= k_len_i;
            feed_cnt_q <= '0;
          end
        end
        ST_FEED: begin
          if (feed_i) begin
            if (feed_cnt_q + 1'b1 == k_q) begin
              state_q <= ST_DRAIN;
              // wavefront needs 2S-2 more edges to reach the far corner
              drain_q <= DCW'(2*S-2);
            end else begin
              feed_cnt_q <= feed_cnt_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (drain_q == '0) state_q <= ST_DONE;
          else               drain_q <= drain_q - 1'b1;
        end
        ST_DONE: begin
          state_q <= ST_READ;
          row_q   <= '0;
        end
        ST_READ: begin
          if (row_q == RW'(S-1)) state_q <= ST_IDLE;
          else                   row_q   <= row_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/osa_array.sv
module osa_array #(
  parameter int S       = 4,
  parameter int DW      = 8,
  parameter int WW      = 8,
  parameter int K_MAX   = 16,
  parameter int A_TRUNC = 1,
  parameter int W_TRUNC = 0,
  parameter int LOA_M   = 4,
  localparam int KW     = $clog2(K_MAX+1),
  localparam int RW     = (S > 1) ? $clog2(S) : 1,
  localparam int AW     = DW + WW + $clog2(K_MAX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [KW-1:0]   k_len_i,
  input  logic            feed_i,
  input  logic [S*DW-1:0] act_i,
  input  logic [S*WW-1:0] wgt_i,
  output logic            done_o,
  output logic            res_valid_o,
  output logic [RW-1:0]   res_row_o,
  output logic [S*AW-1:0] res_data_o
);
  logic clear;
  logic step;

  logic [DW-1:0] a_tr [S];
  logic [WW-1:0] w_tr [S];
  logic [DW-1:0] a_in [S][S];
  logic          v_in [S][S];
  logic [WW-1:0] w_in [S][S];
  logic [AW-1:0] acc  [S][S];

  osa_ctrl #(.S(S), .K_MAX(K_MAX)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .k_len_i    (k_len_i),
    .feed_i     (feed_i),
    .clear_o    (clear),
    .step_o     (step),
    .done_o     (done_o),
    .res_valid_o(res_valid_o),
    .row_o      (res_row_o)
  );

  // Row edge: truncation then r-cycle skew; valid tag rides with activations.
  for (genvar r = 0; r < S; r++) begin : g_row
    osa_trunc #(.W(DW), .T(A_TRUNC)) u_trunc_a (
      .d_i(act_i[r*DW +: DW]),
      .q_o(a_tr[r])
    );
    if (r == 0) begin : g_nodly
      assign a_in[r][0] = a_tr[r];
      assign v_in[r][0] = step;
    end else begin : g_dly
      logic [DW:0] dl_q [r];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < r; k++) dl_q[k] <= '0;
        end else begin
          dl_q[0] <= {step, a_tr[r]};
          for (int k = 1; k < r; k++) dl_q[k] <= dl_q[k-1];
        end
      end
      assign {v_in[r][0], a_in[r][0]} = dl_q[r-1];
    end
  end

  // Column edge: truncation then c-cycle skew.
  for (genvar c = 0; c < S; c++) begin : g_col
    osa_trunc #(.W(WW), .T(W_TRUNC)) u_trunc_w (
      .d_i(wgt_i[c*WW +: WW]),
      .q_o(w_tr[c])
    );
    if (c == 0) begin : g_nodly
      assign w_in[0][c] = w_tr[c];
    end else begin : g_dly
      logic [WW-1:0] dl_q [c];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < c; k++) dl_q[k] <= '0;
        end else begin
          dl_q[0] <= w_tr[c];
          for (int k = 1; k < c; k++) dl_q[k] <= dl_q[k-1];
        end
      end
      assign w_in[0][c] = dl_q[c-1];
    end
  end

  // Element grid with one-hop neighbour forwarding.
  for (genvar r = 0; r < S; r++) begin : g_gr
    for (genvar c = 0; c < S; c++) begin : g_gc
      osa_pe #(.DW(DW), .WW(WW), .AW(AW), .M(LOA_M)) u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(clear),
        .v_i    (v_in[r][c]),
        .a_i    (a_in[r][c]),
        .w_i    (w_in[r][c]),
        .acc_o  (acc[r][c])
      );
      if (c < S-1) begin : g_fwd_h
        logic [DW:0] hq;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hq <= '0;
          else         hq <= {v_in[r][c], a_in[r][c]};
        end
        assign {v_in[r][c+1], a_in[r][c+1]} = hq;
      end
      if (r < S-1) begin : g_fwd_v
        logic [WW-1:0] vq;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) vq <= '0;
          else         vq <= w_in[r][c];
        end
        assign w_in[r+1][c] = vq;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < S; c++) res_data_o[c*AW +: AW] = acc[res_row_o][c];
  end
endmodule

// File: rtl/osa_array_chk.sv
module osa_array_chk #(
  parameter int S  = 4,
  parameter int RW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_i,
  input logic          res_valid_i,
  input logic [RW-1:0] res_row_i
);
  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R6: readout starts at row 0 right after completion
  a_r6_first_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (res_valid_i && res_row_i == '0));

  // R6: rows advance by one on consecutive cycles
  a_r6_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_row_i != RW'(S-1)) |=>
      (res_valid_i && res_row_i == $past(res_row_i) + 1'b1));

  // R6: readout stops after the last row
  a_r6_row_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_row_i == RW'(S-1)) |=> !res_valid_i);

  // R6: completion and readout never overlap
  a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && res_valid_i));
endmodule

bind osa_array osa_array_chk #(.S(S), .RW(RW)) u_osa_array_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_i     (done_o),
  .res_valid_i(res_valid_o),
  .res_row_i  (res_row_o)
);

// File: tb/osa_array_bench.sv
`timescale 1ns/1ps
module osa_array_bench;
  localparam int S     = 4;
  localparam int DW    = 8;
  localparam int WW    = 8;
  localparam int K_MAX = 16;
  localparam int AT    = 1;
  localparam int WT    = 0;
  localparam int LM    = 4;
  localparam int KW    = $clog2(K_MAX+1);
  localparam int RW    = $clog2(S);
  localparam int AW    = DW + WW + $clog2(K_MAX);

  // {k, mode, seed, flags}; mode 0 mixed, 1 all-ones, 2 act=1, 3 gapped, 4 carry pattern
  // flags bit0: stray start mid-tile, bit1: stray feeds while idle
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{4, 0, 3, 0}, '{1, 0, 9, 0}, '{16, 1, 0, 0}, '{7, 2, 5, 0},
    '{3, 4, 0, 0}, '{16, 0, 21, 1}, '{5, 3, 14, 2}, '{2, 0, 40, 0}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [KW-1:0]   k_len_i = '0;
  logic            feed_i = 1'b0;
  logic [S*DW-1:0] act_i = '0;
  logic [S*WW-1:0] wgt_i = '0;
  logic            done_o, res_valid_o;
  logic [RW-1:0]   res_row_o;
  logic [S*AW-1:0] res_data_o;
  logic            ex_done, ex_valid;
  logic [RW-1:0]   ex_row;
  logic [S*AW-1:0] ex_data;

  logic [DW-1:0] a_m [S][K_MAX];
  logic [WW-1:0] b_m [K_MAX][S];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  osa_array #(.S(S), .DW(DW), .WW(WW), .K_MAX(K_MAX), .A_TRUNC(AT), .W_TRUNC(WT),
              .LOA_M(LM)) u_osa_array (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .k_len_i(k_len_i), .feed_i(feed_i),
    .act_i(act_i), .wgt_i(wgt_i), .done_o(done_o), .res_valid_o(res_valid_o),
    .res_row_o(res_row_o), .res_data_o(res_data_o)
  );

  osa_array #(.S(S), .DW(DW), .WW(WW), .K_MAX(K_MAX), .A_TRUNC(0), .W_TRUNC(0),
              .LOA_M(0)) u_osa_exact (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .k_len_i(k_len_i), .feed_i(feed_i),
    .act_i(act_i), .wgt_i(wgt_i), .done_o(ex_done), .res_valid_o(ex_valid),
    .res_row_o(ex_row), .res_data_o(ex_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic longint loa(input longint x, input longint y, input int m);
    longint mask = (longint'(1) << AW) - 1;
    longint lo, hi, cin;
    if (m == 0) return (x + y) & mask;
    lo  = (x | y) & ((longint'(1) << m) - 1);
    cin = (x >> (m-1)) & (y >> (m-1)) & 1;
    hi  = (x >> m) + (y >> m) + cin;
    return ((hi << m) | lo) & mask;
  endfunction

  function automatic longint model(input int r, input int c, input int k,
                                   input int at, input int wt, input int m);
    longint acc = 0;
    for (int t = 0; t < k; t++) begin
      longint a = longint'(a_m[r][t]) & ~((longint'(1) << at) - 1);
      longint w = longint'(b_m[t][c]) & ~((longint'(1) << wt) - 1);
      acc = loa(acc, a * w, m);
    end
    return acc;
  endfunction

  task automatic fill(input int mode, input int seed);
    for (int i = 0; i < S; i++) begin
      for (int t = 0; t < K_MAX; t++) begin
        case (mode)
          1: begin a_m[i][t] = '1; b_m[t][i] = '1; end
          2: begin a_m[i][t] = DW'(1); b_m[t][i] = WW'((seed*19 + i*7 + t*53 + 3) % 256); end
          4: begin a_m[i][t] = DW'(8); b_m[t][i] = WW'(1); end
          default: begin
            a_m[i][t] = DW'((seed*37 + i*11 + t*29 + i*t*7 + 13) % 256);
            b_m[t][i] = WW'((seed*23 + i*17 + t*41 + i*t*5 + 7) % 256);
          end
        endcase
      end
    end
  endtask

  function automatic string tag_of(input int mode, input int flags);
    string s;
    case (mode)
      1: s = "R12";
      2: s = "R2";
      3: s = "R7";
      4: s = "R3";
      default: s = "R4";
    endcase
    if (flags != 0) s = {s, " R9"};
    return s;
  endfunction

  task automatic run_tile(input int k, input int mode, input int flags);
    string tg = tag_of(mode, flags);
    bit done_ok = 1'b1;
    bit valid_ok = 1'b1;
    if (flags[1]) begin
      for (int j = 0; j < 3; j++) begin
        feed_i = 1'b1; act_i = '1; wgt_i = '1;
        @(negedge clk);
      end
      feed_i = 1'b0;
    end
    start_i = 1'b1; k_len_i = KW'(k);
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < k; t++) begin
      if (mode == 3 && (t % 2) == 1) begin
        feed_i = 1'b0; act_i = '1; wgt_i = '1;
        @(negedge clk);
      end
      feed_i = 1'b1;
      for (int i = 0; i < S; i++) begin
        act_i[i*DW +: DW] = a_m[i][t];
        wgt_i[i*WW +: WW] = b_m[t][i];
      end
      start_i = flags[0] && (t == 1);
      k_len_i = (flags[0] && t == 1) ? KW'(1) : KW'(k);
      @(negedge clk);
    end
    feed_i = 1'b0; start_i = 1'b0; k_len_i = KW'(k);
    // n counts edges after the one that accepted the last step
    for (int n = 0; n < 3*S + 2; n++) begin
      bit exp_done  = (n == 2*S - 1);
      bit exp_valid = (n >= 2*S) && (n < 3*S);
      if (done_o !== exp_done) done_ok = 1'b0;
      if (res_valid_o !== exp_valid) valid_ok = 1'b0;
      if (exp_valid) begin
        int r = n - 2*S;
        check(res_row_o == RW'(r), "R6 row index", longint'(res_row_o), r);
        for (int c = 0; c < S; c++) begin
          longint got = longint'(res_data_o[c*AW +: AW]);
          longint exp = model(r, c, k, AT, WT, LM);
          longint gx  = longint'(ex_data[c*AW +: AW]);
          longint ex  = model(r, c, k, 0, 0, 0);
          check(got == exp, {tg, " R3 R4 R8 data"}, got, exp);
          check(gx == ex, {tg, " R11 exact"}, gx, ex);
        end
      end
      @(negedge clk);
    end
    check(done_ok, {tg, " R5 done cycle"}, done_ok, 1);
    check(valid_ok, {tg, " R6 readout window"}, valid_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    bit quiet = 1'b1;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    check(res_valid_o == 1'b0, "R1 valid in reset", res_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0 && res_valid_o == 1'b0, "R1 after release",
          {done_o, res_valid_o}, 0);

    for (int v = 0; v < NV; v++) begin
      fill(VEC[v][1], VEC[v][2]);
      run_tile(VEC[v][0], VEC[v][1], VEC[v][3]);
    end

    // R10: zero-length start followed by stray feeds must stay silent
    start_i = 1'b1; k_len_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    feed_i = 1'b1; act_i = '1; wgt_i = '1;
    repeat (2) @(negedge clk);
    feed_i = 1'b0;
    for (int n = 0; n < 3*S + 4; n++) begin
      if (done_o || res_valid_o) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R10 zero length start", quiet, 1);

    // R8 R9: the next tile sees none of the ignored activity
    fill(0, 77);
    run_tile(6, 0, 0);

    report();
    $finish;
  end
endmodule